// File: doc/BRIEF.md
# System Control Register with Program-Page Mapping

This block is one 8-bit control register sitting on a simple register bus, together with the side-effect logic its bits drive. The register holds an enable for the debug test-port pins, a two-bit field that picks which program-memory page is visible in data space, a flag that hands the upper half of program space to the upper pages, a self-clearing "ROM operation finished" handshake bit and a password-lock bit.

Around the register, the block turns the page field and a byte/word mode input into a one-hot style page-enable vector. It turns a write of the finished bit into a system-reset request and a strobe that clears an external debug flag, and it drops the finished bit when the control unit acknowledges. Two synchronous reset inputs are provided. Power-on reset restores every bit. The other system reset restores every bit except the password lock, which keeps its value.

Top module: `sysctl_reg`

## Requirements
- R1: On either reset input, the register reads 1000_00x0b, where bit 7 is the test-port enable set to 1, the page field and upper-access bit are 0, and the finished bit is 0. Both pulse outputs are low in the cycle after reset.
- R2: Bits 6 and 0 always read 0, whatever value is written to them.
- R3: A write stores bit 7 (testPortEn), bits 5:4 (page field) and bit 3 (upperMapEn), and the read data shows them in the same positions. testPortEn and upperMapEn follow bits 7 and 3.
- R4: In byte mode (byteMode=1), pageEn is one-hot and pageEn[k] is high for page field value k, where pageEn bit k stands for page k.
- R5: In word mode (byteMode=0), a page field with bit 5 = 0 gives pageEn=0011b and a page field with bit 5 = 1 gives pageEn=1100b.
- R6: A write with bit 2 = 1 while dbgFlag is high makes sysRstReq high for exactly the one cycle after the write edge. With dbgFlag low, no request is made.
- R7: dbgFlagClr pulses in exactly the same cycle as sysRstReq and under the same condition.
- R8: Writing bit 2 = 1 sets the finished bit, and doneAck clears it on the next edge. When a write of bit 2 = 1 and doneAck fall in the same cycle, the bit ends up set.
- R9: Bit 1 (pwdLock) is set to 1 by porRst only. sysRst leaves it unchanged, and a write stores bit 1 of the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRst | input | 1 | Power-on reset, active high, synchronous |
| sysRst | input | 1 | Other system reset, active high, synchronous |
| regSel | input | 1 | Register selected on the bus |
| wrEn | input | 1 | Write enable |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Current register value |
| byteMode | input | 1 | 1 = byte access mode, 0 = word access mode |
| dbgFlag | input | 1 | State of the external debug-control flag |
| doneAck | input | 1 | Control unit acknowledges the finished bit |
| testPortEn | output | 1 | Debug test-port pin enable |
| pwdLock | output | 1 | Password lock state |
| upperMapEn | output | 1 | Upper pages mapped into upper program space |
| pageEn | output | 4 | Page enables mapped into data space |
| sysRstReq | output | 1 | One-cycle system-reset request |
| dbgFlagClr | output | 1 | One-cycle strobe clearing the external debug flag |

## Verification
Two events can reach the finished bit in the same cycle: a bus write that sets it and the acknowledge that clears it. The bench raises doneAck on the very edge where a write of 04h lands, then reads the register back, and expects bit 2 to be set. The other cases are covered separately: a plain acknowledge must clear the bit on the next edge, and a full sweep of all 256 write values under both debug-flag states checks that the reset request and the flag-clear strobe appear together, one cycle after the write.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int REG_W    = 8;
  localparam int PAGE_N   = 4;
  localparam int CDA_W    = $clog2(PAGE_N);
  localparam int TAP_BIT  = 7;
  localparam int CDA_LSB  = 4;
  localparam int UPA_BIT  = 3;
  localparam int DONE_BIT = 2;
  localparam int PWL_BIT  = 1;

  typedef struct packed {
    logic wrReg;
    logic setDone;
    logic clrDone;
    logic anyRst;
    logic porRst;
  } ctlStb_t;
endpackage

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
(
  input  logic    clk,
  input  logic    porRst,
  input  logic    sysRst,
  input  logic    regSel,
  input  logic    wrEn,
  input  logic    wrDone,
  input  logic    dbgFlag,
  input  logic    doneAck,
  output ctlStb_t stb,
  output logic    sysRstReq,
  output logic    dbgFlagClr
);
  logic wrReg;
  logic fireReq;

  assign wrReg   = regSel & wrEn;
  assign fireReq = wrReg & wrDone & dbgFlag;

  always_comb begin
    stb.wrReg   = wrReg;
    stb.setDone = wrReg & wrDone;
    stb.clrDone = doneAck & ~(wrReg & wrDone);
    stb.anyRst  = porRst | sysRst;
    stb.porRst  = porRst;
  end

  always_ff @(posedge clk) begin
    if (porRst || sysRst) begin
      sysRstReq  <= 1'b0;
      dbgFlagClr <= 1'b0;
    end else begin
      sysRstReq  <= fireReq;
      dbgFlagClr <= fireReq;
    end
  end

  // R6: done write with flag set yields a request next cycle
  a_r6_req_after_done: assert property (@(posedge clk) disable iff (porRst || sysRst)
    (regSel && wrEn && wrDone && dbgFlag) |=> sysRstReq);
  // R6: request lasts one cycle only when no new write follows
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (porRst || sysRst)
    (sysRstReq && !(regSel && wrEn && wrDone && dbgFlag)) |=> !sysRstReq);
  // R7: strobe and request travel together
  a_r7_pair: assert property (@(posedge clk) disable iff (porRst || sysRst)
    sysRstReq == dbgFlagClr);
endmodule

// File: rtl/sysctl_data.sv
module sysctl_data
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  ctlStb_t           stb,
  input  logic [REG_W-1:0]  wrData,
  input  logic              byteMode,
  output logic [REG_W-1:0]  rdData,
  output logic              testPortEn,
  output logic              pwdLock,
  output logic              upperMapEn,
  output logic [PAGE_N-1:0] pageEn
);
  logic             tapQ;
  logic [CDA_W-1:0] cdaQ;
  logic             upaQ;
  logic             doneQ;
  logic             pwlQ;
  logic             unusedRsvd;

  assign unusedRsvd = ^{wrData[6], wrData[0]};

  always_ff @(posedge clk) begin
    if (stb.anyRst) begin
      tapQ  <= 1'b1;
      cdaQ  <= '0;
      upaQ  <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      if (stb.wrReg) begin
        tapQ <= wrData[TAP_BIT];
        cdaQ <= wrData[CDA_LSB +: CDA_W];
        upaQ <= wrData[UPA_BIT];
      end
      if (stb.setDone)
        doneQ <= 1'b1;
      else if (stb.clrDone)
        doneQ <= 1'b0;
      else if (stb.wrReg)
        doneQ <= wrData[DONE_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (stb.porRst)
      pwlQ <= 1'b1;
    else if (stb.wrReg && !stb.anyRst)
      pwlQ <= wrData[PWL_BIT];
  end

  always_comb begin
    rdData                     = '0;
    rdData[TAP_BIT]            = tapQ;
    rdData[CDA_LSB +: CDA_W]   = cdaQ;
    rdData[UPA_BIT]            = upaQ;
    rdData[DONE_BIT]           = doneQ;
    rdData[PWL_BIT]            = pwlQ;
  end

  assign testPortEn = tapQ;
  assign pwdLock    = pwlQ;
  assign upperMapEn = upaQ;

  for (genvar i = 0; i < PAGE_N; i++) begin : g_page
    localparam logic [CDA_W-1:0] IDX = CDA_W'(i);
    assign pageEn[i] = byteMode ? (cdaQ == IDX)
                                : (cdaQ[CDA_W-1:1] == IDX[CDA_W-1:1]);
  end

  // R4: byte mode selects exactly one page
  a_r4_byte_onehot: assert property (@(posedge clk) disable iff (stb.anyRst)
    byteMode |-> $countones(pageEn) == 1);
  // R5: word mode selects a page pair
  a_r5_word_pair: assert property (@(posedge clk) disable iff (stb.anyRst)
    !byteMode |-> $countones(pageEn) == 2);
  // R9: lock only moves on power-on reset or a write
  a_r9_lock_hold: assert property (@(posedge clk) disable iff (stb.porRst)
    !stb.wrReg |=> $stable(pwdLock));
endmodule

// File: rtl/sysctl_reg.sv
module sysctl_reg
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              porRst,
  input  logic              sysRst,
  input  logic              regSel,
  input  logic              wrEn,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  input  logic              byteMode,
  input  logic              dbgFlag,
  input  logic              doneAck,
  output logic              testPortEn,
  output logic              pwdLock,
  output logic              upperMapEn,
  output logic [PAGE_N-1:0] pageEn,
  output logic              sysRstReq,
  output logic              dbgFlagClr
);
  ctlStb_t stb;

  sysctl_ctrl ctrl_i (
    .clk        (clk),
    .porRst     (porRst),
    .sysRst     (sysRst),
    .regSel     (regSel),
    .wrEn       (wrEn),
    .wrDone     (wrData[DONE_BIT]),
    .dbgFlag    (dbgFlag),
    .doneAck    (doneAck),
    .stb        (stb),
    .sysRstReq  (sysRstReq),
    .dbgFlagClr (dbgFlagClr)
  );

  sysctl_data data_i (
    .clk        (clk),
    .stb        (stb),
    .wrData     (wrData),
    .byteMode   (byteMode),
    .rdData     (rdData),
    .testPortEn (testPortEn),
    .pwdLock    (pwdLock),
    .upperMapEn (upperMapEn),
    .pageEn     (pageEn)
  );

  // R8: acknowledge without a competing set clears the finished bit
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (porRst || sysRst)
    (doneAck && !(regSel && wrEn && wrData[DONE_BIT])) |=> !rdData[DONE_BIT]);
  // R8: set wins over acknowledge
  a_r8_set_wins: assert property (@(posedge clk) disable iff (porRst || sysRst)
    (regSel && wrEn && wrData[DONE_BIT]) |=> rdData[DONE_BIT]);
  // R2: reserved positions stay clear
  a_r2_reserved: assert property (@(posedge clk) disable iff (porRst || sysRst)
    (regSel && wrEn) |=> (rdData[6] == 1'b0 && rdData[0] == 1'b0));
endmodule

// File: tb/sysctl_reg_tb_top.sv
module sysctl_reg_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       porRst, sysRst, regSel, wrEn, byteMode, dbgFlag, doneAck;
  logic [7:0] wrData;
  logic [7:0] rdData;
  logic       testPortEn, pwdLock, upperMapEn, sysRstReq, dbgFlagClr;
  logic [3:0] pageEn;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #(CLK_P/2) clk = ~clk;

  sysctl_reg dut_i (
    .clk(clk), .porRst(porRst), .sysRst(sysRst), .regSel(regSel), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .byteMode(byteMode), .dbgFlag(dbgFlag),
    .doneAck(doneAck), .testPortEn(testPortEn), .pwdLock(pwdLock),
    .upperMapEn(upperMapEn), .pageEn(pageEn), .sysRstReq(sysRstReq),
    .dbgFlagClr(dbgFlagClr)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    regSel = 0; wrEn = 0; wrData = '0; doneAck = 0;
    porRst = 0; sysRst = 0;
  endtask

  function automatic logic [3:0] pagesFor(input logic [1:0] f, input logic bm);
    if (bm) return 4'(1 << f);
    return f[1] ? 4'b1100 : 4'b0011;
  endfunction

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    if (!done) begin
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(); byteMode = 1; dbgFlag = 0;
    porRst = 1;
    @(negedge clk);
    tick();
    porRst = 0;
    check("R1 por value", rdData, 8'h82);
    check("R1 tap out", testPortEn, 1);
    check("R1 pulses low", {sysRstReq, dbgFlagClr}, 0);
    check("R9 lock after por", pwdLock, 1);

    // exhaustive write sweep under both debug-flag states
    for (int v = 0; v < 512; v++) begin
      logic [7:0] d;
      logic       fl;
      logic [7:0] exp;
      d  = v[7:0];
      fl = v[8];
      regSel = 1; wrEn = 1; wrData = d; dbgFlag = fl;
      tick();
      regSel = 0; wrEn = 0;
      exp = d & 8'hBE;
      check("R2 R3 R9 readback", rdData, exp);
      check("R3 testPortEn", testPortEn, d[7]);
      check("R3 upperMapEn", upperMapEn, d[3]);
      check("R6 sysRstReq", sysRstReq, d[2] & fl);
      check("R7 dbgFlagClr", dbgFlagClr, d[2] & fl);
      byteMode = 1; #1;
      check("R4 byte pages", pageEn, pagesFor(d[5:4], 1'b1));
      byteMode = 0; #1;
      check("R5 word pages", pageEn, pagesFor(d[5:4], 1'b0));
      byteMode = 1;
      tick();
      check("R6 pulse single cycle", sysRstReq, 0);
      check("R7 strobe single cycle", dbgFlagClr, 0);
    end
    dbgFlag = 0;

    // acknowledge clears the finished bit
    regSel = 1; wrEn = 1; wrData = 8'h04; tick(); regSel = 0; wrEn = 0;
    check("R8 done set", rdData[2], 1);
    doneAck = 1; tick(); doneAck = 0;
    check("R8 ack clears", rdData[2], 0);

    // same-cycle set and acknowledge: set wins
    regSel = 1; wrEn = 1; wrData = 8'h04; doneAck = 1; tick();
    regSel = 0; wrEn = 0; doneAck = 0;
    check("R8 set beats ack", rdData[2], 1);

    // system reset keeps the lock, clears the rest
    regSel = 1; wrEn = 1; wrData = 8'h3C; tick(); regSel = 0; wrEn = 0;
    check("R9 lock cleared by write", pwdLock, 0);
    sysRst = 1; tick(); sysRst = 0;
    check("R1 R9 sysRst value", rdData, 8'h80);
    regSel = 1; wrEn = 1; wrData = 8'h3E; tick(); regSel = 0; wrEn = 0;
    sysRst = 1; tick(); sysRst = 0;
    check("R1 R9 sysRst keeps lock set", rdData, 8'h82);

    // power-on reset restores the lock
    regSel = 1; wrEn = 1; wrData = 8'h00; tick(); regSel = 0; wrEn = 0;
    porRst = 1; tick(); porRst = 0;
    check("R1 R9 por restores lock", rdData, 8'h82);

    // reset during a pending request drops the pulse
    regSel = 1; wrEn = 1; wrData = 8'h04; dbgFlag = 1; sysRst = 1; tick();
    idle(); dbgFlag = 0;
    check("R1 no pulse through reset", {sysRstReq, dbgFlagClr}, 0);
    check("R1 done cleared by reset", rdData, 8'h82);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule